// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (open-drain clock and data lines, 7-bit addressing). It gives a bus master access to a small file of eight-bit configuration registers. The block runs on a system clock that is much faster than the bus, at least about twenty times the bus bit rate, which makes it suitable for fast-mode traffic up to 400 kbit/s. It samples both bus lines on that clock, detects start and stop conditions and clock edges, and drives the data line only by pulling it low.

A transaction opens with the device address. That address is a fixed five-bit prefix followed by two bits taken from pins, so four such slaves can share one bus. A write carries a command byte and then one or two data bytes. A read first writes the command byte, then issues a repeated start and returns one or two bytes. The command byte holds an access flag in its top bit and a register offset in its low seven bits. After the first data byte, each further byte moves to the next offset. The whole register file is visible in parallel on an output vector, and a single-cycle event pulse tells the rest of the chip when a completed write changed any setting.

Top module: `twi_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal binary 11010 followed by `addrSel[1]`, `addrSel[0]`; the lowest bit is the direction, with 0 for write and 1 for read. On any other address it leaves the ninth bit released and does not pull the data line again until the next start condition.
- R2: After reset, offset 0 reads 0xC3 (the fixed identification byte), and offsets 1 to 6 hold 0x20, 0x30, 0x00, 0x30, 0xBF and 0xF0. Byte k of the file appears on `regBytes[8k+7:8k]`.
- R3: A write consists of address+W, a command byte with bit 7 set and the offset in bits 6:0, then a data byte. The slave acknowledges all three bytes and stores the data at that offset.
- R4: In a write with two data bytes, the first byte goes to the offset and the second goes to offset+1. Each byte is acknowledged.
- R5: A read consists of address+W, the command byte, a repeated start and address+R. The slave then shifts out the register at the offset, most significant bit first, and the offset is kept across the repeated start.
- R6: A read of two bytes returns the offset and then offset+1. The master's NACK after the last byte ends the read, and the slave releases the line.
- R7: Writes to offset 0 or to any offset above 6 are acknowledged and discarded.
- R8: Reads from any offset above 6 return 0x00.
- R9: A command byte with bit 7 clear is acknowledged. Data bytes after it are acknowledged and change no register, and reads after it return 0x00.
- R10: `writeEvent` goes high for exactly one clock after a stop condition that ends a transaction in which at least one register changed value. Writes that leave every value as it was produce no pulse.
- R11: `sdaPullLow` changes only while the bus clock is low, and it is released after a stop condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| addrSel | input | 2 | Pin-selected low bits of the device address |
| sdaPullLow | output | 1 | High to pull the data line low |
| regBytes | output | 56 | Register file contents, byte k at bits 8k+7:8k |
| writeEvent | output | 1 | One-cycle pulse at a stop after a changing write |

## Verification
The address decoder is swept over every pin setting against every low-bit pair, plus a wrong prefix. This separates a matching address from a near miss and shows that a rejected slave stays silent for the rest of the transfer. Single-byte reads and writes are driven at every offset from 0 to 8. This separates the read-only byte, the writable range and the out-of-range offsets, and a fresh pattern value at each offset exposes a write that lands on the wrong register. Two-byte writes and reads, including one that starts at the last register, show the offset stepping. Rewrites of an unchanged value and commands with bit 7 clear separate a real change from a write that only has to produce acknowledges.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_CMD, S_CMD_ACK,
    S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } busState_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic shiftIn;   // sample one received bit
    logic shiftOut;  // advance transmit byte by one bit
    logic loadTx;    // fetch register at pointer into shifter, step pointer
    logic takeCmd;   // latch command byte
    logic commitWr;  // write received byte at pointer, step pointer
    logic stopSeen;  // stop condition on the bus
  } dpStrobe_t;

  function automatic logic [7:0] resetValue(input int idx);
    case (idx)
      1:       return 8'h20;
      2:       return 8'h30;
      3:       return 8'h00;
      4:       return 8'h30;
      5:       return 8'hBF;
      6:       return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond,
  output logic sdaLevel
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclLast, sdaLast;
  logic sclNow, sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclLast <= sclNow;
      sdaLast <= sdaNow;
    end
  end

  assign sclNow    = sclPipe[SYNC_STAGES-1];
  assign sdaNow    = sdaPipe[SYNC_STAGES-1];
  assign sdaLevel  = sdaNow;
  assign sclRise   = sclNow & ~sclLast;
  assign sclFall   = ~sclNow & sclLast;
  // data moving while the clock stays high marks frame boundaries
  assign startCond = sclNow & sclLast & sdaLast & ~sdaNow;
  assign stopCond  = sclNow & sclLast & ~sdaLast & sdaNow;
endmodule

// File: rtl/twi_cfg_ctrl.sv
module twi_cfg_ctrl
  import twi_cfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startCond,
  input  logic       stopCond,
  input  logic       sdaLevel,
  input  logic       addrHit,
  input  logic       rwBit,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       pullLow
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic rwReg, nackReg;
  logic receiving, byteFull;

  assign receiving = (state == S_ADDR) || (state == S_CMD) || (state == S_WR);
  assign byteFull  = (bitCnt == CNT_W'(DATA_W));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      rwReg   <= 1'b0;
      nackReg <= 1'b1;
    end else if (startCond) begin
      state  <= S_ADDR;
      bitCnt <= '0;
    end else if (stopCond) begin
      state  <= S_IDLE;
      bitCnt <= '0;
    end else begin
      if (sclRise && (receiving || state == S_RD)) bitCnt <= bitCnt + 1'b1;
      if (sclRise && state == S_RD_ACK) nackReg <= sdaLevel;
      if (sclFall) begin
        case (state)
          S_ADDR: if (byteFull) begin
            bitCnt <= '0;
            rwReg  <= rwBit;
            state  <= addrHit ? S_ADDR_ACK : S_IDLE;
          end
          S_ADDR_ACK: state <= rwReg ? S_RD : S_CMD;
          S_CMD: if (byteFull) begin
            bitCnt <= '0;
            state  <= S_CMD_ACK;
          end
          S_CMD_ACK: state <= S_WR;
          S_WR: if (byteFull) begin
            bitCnt <= '0;
            state  <= S_WR_ACK;
          end
          S_WR_ACK: state <= S_WR;
          S_RD: if (byteFull) begin
            bitCnt <= '0;
            state  <= S_RD_ACK;
          end
          S_RD_ACK: state <= nackReg ? S_IDLE : S_RD;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.shiftIn  = sclRise && receiving;
    strobe.shiftOut = sclFall && (state == S_RD) && !byteFull;
    strobe.loadTx   = sclFall && (((state == S_ADDR_ACK) && rwReg) ||
                                  ((state == S_RD_ACK) && !nackReg));
    strobe.takeCmd  = sclFall && (state == S_CMD) && byteFull;
    strobe.commitWr = sclFall && (state == S_WR) && byteFull;
    strobe.stopSeen = stopCond;
  end

  assign pullLow = (state == S_ADDR_ACK) || (state == S_CMD_ACK) ||
                   (state == S_WR_ACK) || ((state == S_RD) && !txBit);
endmodule

// File: rtl/twi_cfg_datapath.sv
module twi_cfg_datapath
  import twi_cfg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 7,
  parameter int SEL_W    = 2,
  parameter logic [DATA_W-2-SEL_W:0] ADDR_PREFIX = 5'b11010,
  parameter logic [DATA_W-1:0] MFR_ID = 8'hC3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic                       sdaLevel,
  input  logic [SEL_W-1:0]           addrSel,
  output logic                       addrHit,
  output logic                       rwBit,
  output logic                       txBit,
  output logic [NUM_REGS*DATA_W-1:0] regBytes,
  output logic                       writeEvent
);
  localparam int PTR_W = DATA_W - 1;

  logic [DATA_W-1:0] shiftReg;
  logic [PTR_W-1:0]  ptr;
  logic              cmdValid, dirty;
  logic [DATA_W-1:0] readByte;
  logic              writable, changed;

  assign addrHit = (shiftReg[DATA_W-1:1] == {ADDR_PREFIX, addrSel});
  assign rwBit   = shiftReg[0];
  assign txBit   = shiftReg[DATA_W-1];

  // register slices: offset 0 fixed, others writable with reset defaults
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_ro
      assign regBytes[DATA_W-1:0] = MFR_ID;
    end else begin : g_rw
      logic [DATA_W-1:0] regQ;
      always_ff @(posedge clk) begin
        if (!rstN) regQ <= DATA_W'(resetValue(i));
        else if (strobe.commitWr && cmdValid && ptr == PTR_W'(i)) regQ <= shiftReg;
      end
      assign regBytes[i*DATA_W +: DATA_W] = regQ;
    end
  end

  always_comb begin
    readByte = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (cmdValid && ptr == PTR_W'(i)) readByte = regBytes[i*DATA_W +: DATA_W];
  end

  assign writable = (ptr != '0) && (ptr < PTR_W'(NUM_REGS));
  assign changed  = strobe.commitWr && cmdValid && writable && (readByte != shiftReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      ptr        <= '0;
      cmdValid   <= 1'b0;
      dirty      <= 1'b0;
      writeEvent <= 1'b0;
    end else begin
      writeEvent <= 1'b0;
      if (strobe.shiftIn)  shiftReg <= {shiftReg[DATA_W-2:0], sdaLevel};
      if (strobe.shiftOut) shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
      if (strobe.loadTx) begin
        shiftReg <= readByte;
        ptr      <= ptr + 1'b1;
      end
      if (strobe.takeCmd) begin
        cmdValid <= shiftReg[DATA_W-1];
        ptr      <= shiftReg[PTR_W-1:0];
      end
      if (strobe.commitWr) ptr <= ptr + 1'b1;
      if (changed) dirty <= 1'b1;
      if (strobe.stopSeen) begin
        writeEvent <= dirty;
        dirty      <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave
  import twi_cfg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 7,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-2-SEL_W:0] ADDR_PREFIX = 5'b11010,
  parameter logic [DATA_W-1:0] MFR_ID = 8'hC3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic [SEL_W-1:0]           addrSel,
  output logic                       sdaPullLow,
  output logic [NUM_REGS*DATA_W-1:0] regBytes,
  output logic                       writeEvent
);
  logic sclRise, sclFall, startCond, stopCond, sdaLevel;
  logic addrHit, rwBit, txBit;
  dpStrobe_t strobe;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall), .startCond(startCond),
    .stopCond(stopCond), .sdaLevel(sdaLevel)
  );

  twi_cfg_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .sdaLevel(sdaLevel),
    .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit),
    .strobe(strobe), .pullLow(sdaPullLow)
  );

  twi_cfg_datapath #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W),
    .ADDR_PREFIX(ADDR_PREFIX), .MFR_ID(MFR_ID)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaLevel(sdaLevel),
    .addrSel(addrSel), .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit),
    .regBytes(regBytes), .writeEvent(writeEvent)
  );
endmodule

// File: rtl/twi_cfg_checker.sv
module twi_cfg_checker #(
  parameter int REG_BITS = 56
) (
  input logic                clk,
  input logic                rstN,
  input logic                sclIn,
  input logic                sdaPullLow,
  input logic                writeEvent,
  input logic [REG_BITS-1:0] regBytes,
  input logic                commitWr,
  input logic                stopSeen
);
  // R11: the data line is only grabbed or let go while the clock is low
  p_pull_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaPullLow) || $fell(sdaPullLow)) |-> !sclIn);

  // R11: line released once a stop is seen
  p_release_after_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaPullLow);

  // R10: event is a single clock wide
  p_event_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    writeEvent |=> !writeEvent);

  // R10: event only follows a stop
  p_event_after_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    writeEvent |-> $past(stopSeen));

  // R3: register contents move only when a data byte is committed
  p_regs_move_on_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regBytes) |-> $past(commitWr));
endmodule

bind twi_cfg_slave twi_cfg_checker #(.REG_BITS(NUM_REGS*DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .writeEvent(writeEvent), .regBytes(regBytes),
  .commitWr(strobe.commitWr), .stopSeen(strobe.stopSeen)
);

// File: tb/twi_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module twi_cfg_slave_tb_top;
  localparam int Q = 6;  // system clocks per quarter bus bit

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic [1:0] addrSel = 2'b00;
  logic sdaPullLow, writeEvent;
  logic [55:0] regBytes;
  logic sdaBus;

  int nChecks = 0;
  int nFail = 0;
  int evCount = 0;
  bit done = 0;
  logic [7:0] model [7];

  assign sdaBus = sdaDrv & ~sdaPullLow;

  always #10 clk = ~clk;

  twi_cfg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .addrSel(addrSel), .sdaPullLow(sdaPullLow),
    .regBytes(regBytes), .writeEvent(writeEvent)
  );

  always @(posedge clk) if (rstN && writeEvent) evCount++;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b1; tick(2*Q);
  endtask

  task automatic putBit(input logic b);
    sdaDrv = b; tick(Q);
    sclDrv = 1'b1; tick(2*Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic getBit(output logic b);
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    b = sdaBus; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ackLow);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    ackLow = !b;
  endtask

  task automatic recvByte(input logic last, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) getBit(v[i]);
    putBit(last);
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] cmd, input int k);
    int off;
    off = int'(cmd[6:0]) + k;
    if (!cmd[7] || off > 6) return 8'h00;
    return model[off];
  endfunction

  task automatic checkRegs(input string req);
    for (int i = 0; i < 7; i++)
      check(req, $sformatf("regBytes byte %0d", i), int'(regBytes[i*8 +: 8]), int'(model[i]));
  endtask

  task automatic writeTxn(input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1,
                          input int n, input string req);
    logic a;
    logic [7:0] v;
    int ev0, off, chg;
    ev0 = evCount;
    chg = 0;
    off = int'(cmd[6:0]);
    busStart();
    sendByte({5'b11010, addrSel, 1'b0}, a); check(req, "address ack", int'(a), 1);
    sendByte(cmd, a);                        check(req, "command ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      v = (k == 0) ? d0 : d1;
      sendByte(v, a); check(req, "data ack", int'(a), 1);
      if (cmd[7] && off >= 1 && off <= 6) begin
        if (model[off] != v) chg = 1;
        model[off] = v;
      end
      off++;
    end
    busStop();
    tick(4);
    check("R10", "write event count", evCount - ev0, chg);
  endtask

  task automatic readTxn(input logic [7:0] cmd, input int n, input string req);
    logic a;
    logic [7:0] r;
    busStart();
    sendByte({5'b11010, addrSel, 1'b0}, a); check(req, "address ack", int'(a), 1);
    sendByte(cmd, a);                        check(req, "command ack", int'(a), 1);
    busStart();
    sendByte({5'b11010, addrSel, 1'b1}, a); check(req, "read address ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k == n - 1, r);
      check(req, $sformatf("read cmd %0h byte %0d", cmd, k), int'(r), int'(expRead(cmd, k)));
    end
    busStop();
    check("R6", "line released after read", int'(sdaPullLow), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic a;
    model[0] = 8'hC3; model[1] = 8'h20; model[2] = 8'h30; model[3] = 8'h00;
    model[4] = 8'h30; model[5] = 8'hBF; model[6] = 8'hF0;
    tick(5);
    rstN = 1'b1;
    tick(4);

    // R2: defaults after reset
    checkRegs("R2");
    check("R11", "idle line released", int'(sdaPullLow), 0);

    // R1: address sweep over pin settings and low bits
    for (int sel = 0; sel < 4; sel++) begin
      addrSel = 2'(sel);
      for (int lo = 0; lo < 4; lo++) begin
        busStart();
        sendByte({5'b11010, 2'(lo), 1'b0}, a);
        check("R1", $sformatf("ack sel %0d low %0d", sel, lo), int'(a), int'(lo == sel));
        if (lo != sel) begin
          sendByte(8'h80, a);
          check("R1", "silent after mismatch", int'(a), 0);
        end
        busStop();
      end
    end
    busStart();
    sendByte({7'b1011010, 1'b0}, a);
    check("R1", "wrong prefix", int'(a), 0);
    busStop();
    check("R11", "released after stop", int'(sdaPullLow), 0);

    addrSel = 2'b10;

    // R5, R8: single-byte reads at every offset
    for (int off = 0; off < 9; off++)
      readTxn(8'h80 | 8'(off), 1, off > 6 ? "R8" : "R5");

    // R3, R7, R10: single-byte writes at every offset
    for (int off = 0; off < 9; off++) begin
      writeTxn(8'h80 | 8'(off), 8'(off * 41 + 17), 8'h00, 1,
               (off == 0 || off > 6) ? "R7" : "R3");
      checkRegs((off == 0 || off > 6) ? "R7" : "R3");
    end

    // R10: rewriting the same value gives no event
    writeTxn(8'h82, model[2], 8'h00, 1, "R10");
    checkRegs("R10");

    // R4: word write, and one that runs past the last register
    writeTxn(8'h83, 8'h5C, 8'hA7, 2, "R4");
    checkRegs("R4");
    writeTxn(8'h86, 8'h3E, 8'h99, 2, "R4");
    checkRegs("R4");

    // R6: word reads across the file
    for (int off = 0; off < 7; off++)
      readTxn(8'h80 | 8'(off), 2, "R6");

    // R9: command with top bit clear
    writeTxn(8'h03, 8'hEE, 8'h11, 2, "R9");
    checkRegs("R9");
    readTxn(8'h01, 2, "R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule